// File: doc/BRIEF.md
# Port edge interrupt controller

This block watches eight external input pins and turns edges on them into one interrupt request. Each pin has its own polarity bit that picks the rising or the falling edge as the active one. When the active edge arrives, a sticky pending flag for that pin is set. The flag stays set until software writes a 1 to its bit. A per-pin enable bit decides whether that pending flag drives the shared request line. Flags record edges even while their pin is masked, so software can poll them.

Software reaches three 8-bit registers through a simple single-cycle register bus: polarity, enable and pending flags. Reads are combinational. Writes take effect at the next clock edge. Pin inputs are asynchronous to the clock and pass through a two-stage synchronizer before edge detection. The request output is registered.

Top module: `port_edge_irq`

## Requirements
- R1: After reset the polarity, enable and flag registers all read 0x00 and `irq` is 0.
- R2: With `bus_sel` high, a write with `bus_wr` high stores `bus_wdata` into the register at `bus_addr`: polarity at 0x65, enable at 0x66. A read returns that register on `bus_rdata`. Any other address reads as 0x00.
- R3: A polarity bit of 1 makes a rising pin edge active, and a bit of 0 makes a falling edge active. A pin change applied before clock edge k shows as a set flag bit (address 0x67, bit n for pin n) after clock edge k+2.
- R4: Writing a 1 to a flag bit clears it. Writing a 0 to a flag bit leaves it unchanged.
- R5: A flag bit is set by its active edge even while its enable bit is 0. In that case the pin does not raise `irq`.
- R6: When an active edge and a write-1 clear reach the same flag bit in the same cycle, the flag ends up set.
- R7: `irq` is 1 in the cycle after some bit has both flag and enable set, and 0 in the cycle after no such bit exists.
- R8: An edge of the inactive polarity does not set the flag bit.
- R9: Writing a 1 to a flag bit that is already 0 does not set it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 8 | Asynchronous port pin levels, bit n is pin n |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational on the address |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions assume that edges reach the detector only through the synchronizer. They also assume that a flag write is a single-cycle strobe whose data is stable at the clock edge. The bench changes pins and bus inputs only on the falling clock edge and keeps every pin low through reset, so no edge is detected from the reset level. For the set-versus-clear race, the bench times the clear write to land exactly on the cycle in which the synchronized edge becomes visible.

// File: rtl/port_edge_irq.sv
module port_edge_irq #(
  parameter int NPIN = 8,
  parameter int AW = 8,
  parameter logic [AW-1:0] A_POL  = 8'h65,
  parameter logic [AW-1:0] A_EN   = 8'h66,
  parameter logic [AW-1:0] A_FLAG = 8'h67
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pin_i,
  input  logic            bus_sel,
  input  logic            bus_wr,
  input  logic [AW-1:0]   bus_addr,
  input  logic [NPIN-1:0] bus_wdata,
  output logic [NPIN-1:0] bus_rdata,
  output logic            irq
);

  logic [NPIN-1:0] sync1, sync2, prev;
  logic [NPIN-1:0] pol_q, en_q, flag_q;
  logic [NPIN-1:0] hit, clr;
  logic            wr, pol_wr, en_wr, flag_wr;

  assign wr      = bus_sel & bus_wr;
  assign pol_wr  = wr && (bus_addr == A_POL);
  assign en_wr   = wr && (bus_addr == A_EN);
  assign flag_wr = wr && (bus_addr == A_FLAG);

  assign hit = (sync2 & ~prev & pol_q) | (~sync2 & prev & ~pol_q);
  assign clr = flag_wr ? bus_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      prev  <= '0;
    end else begin
      sync1 <= pin_i;
      sync2 <= sync1;
      prev  <= sync2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q  <= '0;
      en_q   <= '0;
      flag_q <= '0;
      irq    <= 1'b0;
    end else begin
      if (pol_wr) pol_q <= bus_wdata;
      if (en_wr)  en_q  <= bus_wdata;
      flag_q <= (flag_q & ~clr) | hit;
      irq    <= |(flag_q & en_q);
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel) begin
      if (bus_addr == A_POL)       bus_rdata = pol_q;
      else if (bus_addr == A_EN)   bus_rdata = en_q;
      else if (bus_addr == A_FLAG) bus_rdata = flag_q;
    end
  end

endmodule

// File: rtl/port_edge_irq_chk.sv
module port_edge_irq_chk #(
  parameter int NPIN = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NPIN-1:0] flag_q,
  input logic [NPIN-1:0] en_q,
  input logic [NPIN-1:0] hit,
  input logic            flag_wr,
  input logic [NPIN-1:0] bus_wdata,
  input logic            irq
);

  // R3, R5 and R6: a detected edge always leaves its flag set, whatever the clear and enable bits hold
  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (hit != '0) |=> ((flag_q & $past(hit)) == $past(hit)));

  a_r4_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    flag_wr |=> ((flag_q & $past(flag_q & ~bus_wdata)) == $past(flag_q & ~bus_wdata)));

  a_r4_one_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flag_wr |=> ((flag_q & $past(bus_wdata & ~hit)) == '0));

  a_r9_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
    (hit == '0) |=> ((flag_q & ~$past(flag_q)) == '0));

  a_r7_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_q & en_q) != '0) |=> irq);

  a_r7_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_q & en_q) == '0) |=> !irq);

endmodule

bind port_edge_irq port_edge_irq_chk #(.NPIN(NPIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .flag_q(flag_q), .en_q(en_q), .hit(hit),
  .flag_wr(flag_wr), .bus_wdata(bus_wdata), .irq(irq)
);

// File: tb/sim_port_edge_irq.sv
`timescale 1ns/1ps
module sim_port_edge_irq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pin_i = '0;
  logic       bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_addr = '0, bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq;

  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  port_edge_irq u0 (.clk(clk), .rst_n(rst_n), .pin_i(pin_i), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq));

  logic [7:0] m_pol = '0, m_en = '0, m_flag = '0;
  logic       m_irq = 1'b0;
  logic [7:0] hq[$] = '{8'h0, 8'h0, 8'h0};

  function automatic logic [7:0] mread(input logic [7:0] a);
    if (!bus_sel) return 8'h0;
    case (a)
      8'h65: return m_pol;
      8'h66: return m_en;
      8'h67: return m_flag;
      default: return 8'h0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  always @(posedge clk) begin
    logic [7:0] act, clrm;
    if (!rst_n) begin
      m_pol = '0; m_en = '0; m_flag = '0; m_irq = 1'b0;
      hq = '{8'h0, 8'h0, 8'h0};
    end else begin
      act  = (hq[1] & ~hq[2] & m_pol) | (~hq[1] & hq[2] & ~m_pol);
      clrm = (bus_sel && bus_wr && bus_addr == 8'h67) ? bus_wdata : 8'h0;
      m_irq = |(m_flag & m_en);
      m_flag = (m_flag & ~clrm) | act;
      if (bus_sel && bus_wr && bus_addr == 8'h66) m_en = bus_wdata;
      if (bus_sel && bus_wr && bus_addr == 8'h65) m_pol = bus_wdata;
      hq.push_front(pin_i);
      void'(hq.pop_back());
    end
    #2;
    chk("R7 model irq", {7'h0, irq}, {7'h0, m_irq});
    chk("R2 model rdata", bus_rdata, mread(bus_addr));
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [7:0] a, input logic [7:0] exp);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp);
    bus_sel = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #2000000;
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    rd("R1 pol", 8'h65, 8'h00);
    rd("R1 en", 8'h66, 8'h00);
    rd("R1 flag", 8'h67, 8'h00);
    chk("R1 irq", {7'h0, irq}, 8'h00);

    wr(8'h66, 8'hA5); rd("R2 en", 8'h66, 8'hA5);
    wr(8'h65, 8'h3C); rd("R2 pol", 8'h65, 8'h3C);
    rd("R2 other", 8'h10, 8'h00);
    wr(8'h66, 8'h00); wr(8'h65, 8'h01);

    pin_i = 8'h01; cyc(4);
    rd("R3 rising", 8'h67, 8'h01);
    pin_i = 8'h03; cyc(4);
    rd("R8 inactive rise", 8'h67, 8'h01);
    pin_i = 8'h01; cyc(4);
    rd("R3 falling", 8'h67, 8'h03);
    chk("R5 masked irq", {7'h0, irq}, 8'h00);

    wr(8'h66, 8'h02); cyc(2);
    chk("R7 irq set", {7'h0, irq}, 8'h01);
    wr(8'h67, 8'h00);
    rd("R4 zero keeps", 8'h67, 8'h03);
    wr(8'h67, 8'h02);
    rd("R4 one clears", 8'h67, 8'h01);
    cyc(2);
    chk("R7 irq clear", {7'h0, irq}, 8'h00);

    wr(8'h67, 8'h80);
    rd("R9 clear of zero", 8'h67, 8'h01);
    wr(8'h67, 8'h01);
    rd("R4 all clear", 8'h67, 8'h00);

    wr(8'h65, 8'h04);
    pin_i = 8'h05; cyc(2);
    wr(8'h67, 8'h04);
    rd("R6 set wins", 8'h67, 8'h04);

    wr(8'h66, 8'h00);
    pin_i = 8'h00; cyc(4);
    rd("R5 masked latch", 8'h67, 8'h05);
    cyc(2);
    chk("R5 still no irq", {7'h0, irq}, 8'h00);
    cyc(2);
    finish_run();
  end
endmodule